// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer

The block is a periodic interval timer with two independent channels, numbered 0 and 2. Software configures the block through one byte-wide register bus. A control-word port selects a channel and stores a small configuration field for it. A data port per channel loads a 16-bit reload count as two bytes, low byte first.

A fractional-accumulator prescaler turns the system clock into count ticks at the nominal timer input rate. Once a channel is loaded, it counts those ticks. After the programmed number of ticks it emits a one-cycle expiry pulse, raises a status flag and reloads itself, so the pulses repeat at a fixed period.

Reading a channel's status port returns the flag together with the stored configuration. The same read clears the flag. A badly formed control word produces an error pulse and leaves the channel configuration as it was.

Top module: `ivt_top`

## Requirements
- R1: After reset both expiry outputs and the error output are low, both status reads return 0x00, and no channel expires until it has been loaded.
- R2: A control write (address 3) uses bits [7:6] as the channel selector: 0 picks channel 0 and 2 picks channel 2. Selector 1 or 3 raises `err` for one cycle, starting the cycle after the write, and changes no configuration.
- R3: A control write whose bits [5:4] are not 2'b11 raises `err` for one cycle and leaves the selected channel's configuration unchanged.
- R4: A valid control write stores bits [3:0] as the selected channel's configuration. The channel's status byte reports the stored value in bits [3:0].
- R5: The data ports are address 0 (channel 0) and address 2 (channel 2). They share a single byte-order flag. A data write with the flag clear latches the low byte and sets the flag. A data write with the flag set loads {byte, low byte} into the channel addressed by that second write and clears the flag.
- R6: Any control write clears the byte-order flag, whether or not the write is accepted.
- R7: With SYS_HZ system clock cycles per TICK_HZ ticks, count tick n (n = system edges since reset release) occurs exactly when floor(n·TICK_HZ/SYS_HZ) increases.
- R8: After a load of count N, a channel's `expire` bit pulses high for one cycle, visible after the N-th tick edge. The channel then reloads N and repeats every N ticks.
- R9: A loaded count of 0 gives an interval of 65536 ticks.
- R10: A load restarts the countdown at once. A load on the same edge as an expiry suppresses that expiry.
- R11: An expiry sets status bit 5. A status read (rd_en at the channel's address) clears bit 5 on that edge, unless an expiry happens on the same edge, in which case bit 5 stays set.
- R12: Address 0 reads channel 0 status and address 2 reads channel 2 status. Addresses 1 and 3 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears the addressed status flag |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational from addr) |
| expire | output | 2 | Expiry pulses; bit 0 is channel 0, bit 1 is channel 2 |
| err | output | 1 | One-cycle pulse after a rejected control word |

## Verification
Two operations can hit a channel's state on the same edge. A status read can clear the flag while an expiry sets it. A second data byte can reload the count while the old count expires. The bench keeps an arithmetic tick schedule and uses it to find the negedge just before a predicted expiry. At that negedge it issues the read or the reloading byte. It then judges the result: the flag must still read as set, and no expiry pulse may appear for the reloaded channel.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned NUM_CH = 2;
    localparam int unsigned FLAG_BIT = 5;

    localparam logic [1:0] PORT_T0   = 2'd0;
    localparam logic [1:0] PORT_NONE = 2'd1;
    localparam logic [1:0] PORT_T2   = 2'd2;
    localparam logic [1:0] PORT_CTRL = 2'd3;

    typedef enum logic [1:0] {
        SEL_T0 = 2'd0,
        SEL_T1 = 2'd1,
        SEL_T2 = 2'd2,
        SEL_RB = 2'd3
    } chan_sel_e;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } access_e;

    typedef struct packed {
        chan_sel_e   sel;
        access_e     acc;
        logic [3:0]  cfg;
    } ctrl_word_t;

    function automatic logic [1:0] slot_port(input int i);
        return (i == 0) ? PORT_T0 : PORT_T2;
    endfunction

    function automatic chan_sel_e slot_sel(input int i);
        return (i == 0) ? SEL_T0 : SEL_T2;
    endfunction

    function automatic logic [7:0] status_byte(input logic flag, input logic [3:0] cfg);
        logic [7:0] s;
        s = 8'h00;
        s[FLAG_BIT] = flag;
        s[3:0] = cfg;
        return s;
    endfunction

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int unsigned SYS_HZ  = 125_000_000,
    parameter int unsigned TICK_HZ = 1_193_180
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned AW = $clog2(2 * SYS_HZ + 1);
    localparam logic [AW-1:0] STEP = TICK_HZ[AW-1:0];
    localparam logic [AW-1:0] WRAP = SYS_HZ[AW-1:0];

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum;
    logic          wrap_now;

    always_comb begin
        sum      = acc_q + STEP;
        wrap_now = (sum >= WRAP);
        tick     = !rst && wrap_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (wrap_now) begin
            acc_q <= sum - WRAP;
        end else begin
            acc_q <= sum;
        end
    end

    // R7: accumulator residue stays below one full period
    p_acc_range_r7: assert property (@(posedge clk) disable iff (rst) acc_q < WRAP);

endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl import ivt_pkg::*; (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [7:0]          wdata,
    output logic [NUM_CH-1:0]   prog,
    output logic [CNT_W-1:0]    load_val,
    output logic [NUM_CH-1:0]   cfg_we,
    output logic [3:0]          cfg_val,
    output logic                err
);
    ctrl_word_t          cw;
    logic                cw_wr;
    logic                cw_ok;
    logic [NUM_CH-1:0]   data_wr;
    logic                pend_q;
    logic [7:0]          low_q;
    logic                err_q;

    assign cw      = ctrl_word_t'(wdata);
    assign cw_wr   = wr_en && (addr == PORT_CTRL);
    assign cw_ok   = ((cw.sel == SEL_T0) || (cw.sel == SEL_T2)) && (cw.acc == ACC_LOHI);
    assign cfg_val = cw.cfg;
    assign load_val = {wdata, low_q};
    assign err     = err_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        assign data_wr[i] = wr_en && (addr == slot_port(i));
        assign prog[i]    = data_wr[i] && pend_q;
        assign cfg_we[i]  = cw_wr && cw_ok && (cw.sel == slot_sel(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            low_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= cw_wr && !cw_ok;
            if (cw_wr) begin
                pend_q <= 1'b0;
            end else if (|data_wr) begin
                pend_q <= !pend_q;
                if (!pend_q) begin
                    low_q <= wdata;
                end
            end
        end
    end

    // R2, R3: an error pulse only ever follows a control-port write
    p_err_source_r2: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(wr_en && (addr == PORT_CTRL)));
    // R6: a control write leaves the byte-order flag clear
    p_seq_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && (addr == PORT_CTRL)) |-> !pend_q);
    // R5: at most one channel loads per cycle
    p_prog_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(prog));
    // R5: a load consumes the pending low byte
    p_load_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (|prog) |=> !pend_q);

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel import ivt_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             prog,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_val,
    input  logic             stat_clr,
    output logic             expire,
    output logic [7:0]       status
);
    localparam int unsigned RW = CNT_W + 1;
    localparam logic [RW-1:0] FULL_RANGE = {1'b1, {CNT_W{1'b0}}};
    localparam logic [RW-1:0] ONE        = {{CNT_W{1'b0}}, 1'b1};

    logic [RW-1:0] reload_q;
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] load_ext;
    logic          armed_q;
    logic          expire_q;
    logic          flag_q;
    logic [3:0]    cfg_q;
    logic          hit;

    assign load_ext = (load_val == '0) ? FULL_RANGE : {1'b0, load_val};
    assign hit      = armed_q && tick && (cnt_q == ONE) && !prog;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            cnt_q    <= '0;
            armed_q  <= 1'b0;
            expire_q <= 1'b0;
            flag_q   <= 1'b0;
            cfg_q    <= '0;
        end else begin
            expire_q <= hit;
            if (prog) begin
                reload_q <= load_ext;
                cnt_q    <= load_ext;
                armed_q  <= 1'b1;
            end else if (armed_q && tick) begin
                cnt_q <= hit ? reload_q : (cnt_q - ONE);
            end
            if (hit) begin
                flag_q <= 1'b1;
            end else if (stat_clr) begin
                flag_q <= 1'b0;
            end
            if (cfg_we) begin
                cfg_q <= cfg_val;
            end
        end
    end

    assign expire = expire_q;
    assign status = status_byte(flag_q, cfg_q);

    // R8: a running count never sits at zero nor above its reload
    p_cnt_live_r8: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> ((cnt_q != '0) && (cnt_q <= reload_q)));
    // R8: an expiry pulse follows a tick edge
    p_expire_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        expire_q |-> $past(tick));
    // R10: a load edge never produces an expiry
    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        $past(prog) |-> !expire_q);
    // R9: a zero load starts a full-range countdown
    p_zero_full_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(prog) && ($past(load_val) == '0)) |-> (cnt_q == FULL_RANGE));
    // R11: every expiry leaves the status flag set
    p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
        expire_q |-> flag_q);

endmodule

// File: rtl/ivt_top.sv
module ivt_top import ivt_pkg::*; #(
    parameter int unsigned SYS_HZ  = 125_000_000,
    parameter int unsigned TICK_HZ = 1_193_180
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NUM_CH-1:0] expire,
    output logic              err
);
    logic               tick;
    logic [NUM_CH-1:0]  prog;
    logic [CNT_W-1:0]   load_val;
    logic [NUM_CH-1:0]  cfg_we;
    logic [3:0]         cfg_val;
    logic [7:0]         stat [NUM_CH];

    ivt_prescaler #(
        .SYS_HZ  (SYS_HZ),
        .TICK_HZ (TICK_HZ)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    ivt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .prog     (prog),
        .load_val (load_val),
        .cfg_we   (cfg_we),
        .cfg_val  (cfg_val),
        .err      (err)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ivt_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .prog     (prog[i]),
            .load_val (load_val),
            .cfg_we   (cfg_we[i]),
            .cfg_val  (cfg_val),
            .stat_clr (rd_en && (addr == slot_port(i))),
            .expire   (expire[i]),
            .status   (stat[i])
        );
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == slot_port(i)) begin
                rdata = stat[i];
            end
        end
    end

    // R12: the unused and control addresses read as zero
    p_rdata_idle_r12: assert property (@(posedge clk) disable iff (rst)
        ((addr == PORT_NONE) || (addr == PORT_CTRL)) |-> (rdata == 8'h00));

endmodule

// File: tb/ivt_top_tb_top.sv
module ivt_top_tb_top;
    localparam int unsigned S = 3;
    localparam int unsigned T = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] expire;
    logic       err;

    always #4 clk = ~clk;

    ivt_top #(.SYS_HZ(S), .TICK_HZ(T)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .expire(expire), .err(err)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // ---- requirement-level reference state ----
    longint     n;
    bit         pend;
    logic [7:0] lowb;
    bit         m_err;
    int         m_cnt [2];
    int         m_rel [2];
    bit         m_arm [2];
    bit         m_exp [2];
    bit         m_flag [2];
    logic [3:0] m_cfg [2];

    function automatic bit tick_at(longint k);
        return ((k * T) / S) != (((k - 1) * T) / S);
    endfunction

    function automatic logic [1:0] port_of(int c);
        return (c == 0) ? 2'd0 : 2'd2;
    endfunction

    function automatic logic [7:0] mstat(int c);
        return {2'b00, m_flag[c], 1'b0, m_cfg[c]};
    endfunction

    // first edge index at which the tick count since edge p reaches v
    function automatic longint due_edge(longint p, longint v);
        longint target;
        target = ((p * T) / S) + v;
        return (target * S + T - 1) / T;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            n = 0; pend = 0; lowb = 8'h00; m_err = 0;
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 0; m_rel[c] = 0; m_arm[c] = 0;
                m_exp[c] = 0; m_flag[c] = 0; m_cfg[c] = 4'h0;
            end
        end else begin
            bit tk;
            n = n + 1;
            tk = tick_at(n);
            for (int c = 0; c < 2; c++) begin
                bit pg;
                bit hit;
                int val;
                pg  = wr_en && (addr == port_of(c)) && pend;
                hit = m_arm[c] && tk && (m_cnt[c] == 1) && !pg;
                m_exp[c] = hit;
                if (pg) begin
                    val = int'({wdata, lowb});
                    m_rel[c] = (val == 0) ? 65536 : val;
                    m_cnt[c] = m_rel[c];
                    m_arm[c] = 1;
                end else if (m_arm[c] && tk) begin
                    m_cnt[c] = hit ? m_rel[c] : m_cnt[c] - 1;
                end
                if (hit) m_flag[c] = 1;
                else if (rd_en && (addr == port_of(c))) m_flag[c] = 0;
            end
            m_err = 0;
            if (wr_en && addr == 2'd3) begin
                bit ok;
                ok = ((wdata[7:6] == 2'd0) || (wdata[7:6] == 2'd2)) && (wdata[5:4] == 2'b11);
                m_err = !ok;
                pend = 0;
                if (ok) m_cfg[(wdata[7:6] == 2'd0) ? 0 : 1] = wdata[3:0];
            end else if (wr_en && (addr == 2'd0 || addr == 2'd2)) begin
                if (!pend) lowb = wdata;
                pend = !pend;
            end
        end
    end

    // per-cycle comparison of pulses (R8) and error (R2/R3)
    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (expire !== {m_exp[1], m_exp[0]} || err !== m_err) begin
                fails++;
                $display("FAIL R8 cycle %0d expire/err act=%b/%b exp=%b%b/%b",
                         n, expire, err, m_exp[1], m_exp[0], m_err);
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(tag, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_due(int c);
        while (!(m_arm[c] && m_cnt[c] == 1 && tick_at(n + 1))) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", n);
            finish_run();
        end
    end

    initial begin
        longint p;
        longint e;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 expire", expire, 0);
        chk("R1 err", err, 0);
        rd(2'd0, 8'h00, "R1 status0");
        rd(2'd2, 8'h00, "R1 status2");
        idle(20);
        chk("R1 idle expire", expire, 0);

        // R4: configuration stored and reported
        wr(2'd3, 8'h35);
        rd(2'd0, 8'h05, "R4 cfg ch0");
        wr(2'd3, 8'hB6);
        rd(2'd2, 8'h06, "R4 cfg ch2");

        // R2: bad selector
        wr(2'd3, 8'h7F);
        chk("R2 sel1 err", err, 1);
        wr(2'd3, 8'hF2);
        chk("R2 sel3 err", err, 1);
        rd(2'd0, 8'h05, "R2 ch0 unchanged");
        rd(2'd2, 8'h06, "R2 ch2 unchanged");

        // R3: bad access mode
        wr(2'd3, 8'h1A);
        chk("R3 acc err", err, 1);
        rd(2'd0, 8'h05, "R3 ch0 unchanged");
        wr(2'd3, 8'hAE);
        chk("R3 acc err ch2", err, 1);
        rd(2'd2, 8'h06, "R3 ch2 unchanged");

        // R7/R8: sweep of small counts plus one larger, two intervals each
        for (int v = 1; v <= 9; v++) begin
            wr(2'd0, 8'(v)); wr(2'd0, 8'h00);
            p = n;
            chk("R10 no pulse on load", expire[0], 0);
            while (!expire[0]) @(negedge clk);
            e = due_edge(p, v);
            chk("R7 first interval", n, e);
            @(negedge clk);
            while (!expire[0]) @(negedge clk);
            chk("R8 periodic reload", n, due_edge(e, v));
        end
        wr(2'd0, 8'h2C); wr(2'd0, 8'h01);
        p = n;
        while (!expire[0]) @(negedge clk);
        chk("R7 count 300", n, due_edge(p, 300));

        // R5: shared byte-order flag, low byte via ch0, high byte via ch2
        wr(2'd0, 8'h05); wr(2'd2, 8'h00);
        p = n;
        while (!expire[1]) @(negedge clk);
        chk("R5 cross-port load", n, due_edge(p, 5));

        // R6: control write drops a pending low byte
        wr(2'd2, 8'h09); wr(2'd3, 8'hB6); wr(2'd2, 8'h02); wr(2'd2, 8'h00);
        p = n;
        while (!expire[1]) @(negedge clk);
        chk("R6 flag cleared", n, due_edge(p, 2));

        // R10: load lands on the expiry edge
        wr(2'd0, 8'h04); wr(2'd0, 8'h00);
        wr(2'd0, 8'h06);
        @(negedge clk);
        wait_due(0);
        addr = 2'd0; wdata = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        p = n;
        chk("R10 expiry suppressed", expire[0], 0);
        while (!expire[0]) @(negedge clk);
        chk("R10 restart interval", n, due_edge(p, 6));

        // R11: status read on the expiry edge keeps the flag
        @(negedge clk);
        wait_due(1);
        addr = 2'd2; rd_en = 1'b1;
        @(negedge clk);
        #1;
        chk("R11 set wins over clear", rdata, 8'h26);
        @(negedge clk);
        rd_en = 1'b0;

        // R9: zero count is a full range; also clears flag quietly
        wr(2'd2, 8'h00); wr(2'd2, 8'h00);
        p = n;
        rd(2'd2, mstat(1), "R11 read");
        rd(2'd2, 8'h06, "R11 flag cleared");

        // R12: unused and control addresses read zero
        rd(2'd1, 8'h00, "R12 addr1");
        rd(2'd3, 8'h00, "R12 addr3");
        rd(2'd0, mstat(0), "R12 addr0");

        while (!expire[1]) @(negedge clk);
        chk("R9 full range", n, due_edge(p, 65536));
        idle(2);
        rd(2'd2, 8'h26, "R11 flag after expiry");

        finish_run();
    end

endmodule